// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms operand addresses for a 32-bit processor whose instructions carry 16-bit extension words after the opcode. Once the opcode is decoded, the core gives the unit an addressing-mode code, an operand size, the number and value of the selected address register, an index register value and the address of the first extension word. A one-cycle `start` strobe begins the work. The unit then pulls zero, one or two extension words over a valid/ready handshake. It returns the effective address, or the assembled immediate operand for immediate mode, with a one-cycle `done` strobe. In the auto-increment and auto-decrement modes it also gives the new address register value with a write enable.

The control is a four-state machine. **IDLE** waits for `start`. From there, the transition *start-no-ext* goes straight to **DONE**, and *start-ext* goes to **WAIT_FIRST**. In **WAIT_FIRST**, *first-last* moves to **DONE** when the mode needs one word, and *first-more* moves to **WAIT_SECOND** when it needs two. From **WAIT_SECOND**, *second-last* moves to **DONE**. From **DONE**, *retire* returns to **IDLE**. Synchronous reset forces **IDLE** from any state. The operand context is captured when `start` is accepted. A two-word value takes its upper half from the first word.

Top module: `ea_gen_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `done`, `wb_en` and `ext_ready` are 0 and `ea_out`, `imm_out` and `wb_val` read 0.
- R2: Mode codes: 0 register indirect, 1 postincrement, 2 predecrement, 3 register+displacement, 4 register+index, 5 absolute short, 6 absolute long, 7 PC+displacement, 8 PC+index, 9 immediate. Codes 10–15 act as mode 0. Modes 0–2 use no extension word, and `done` rises in the cycle right after the `start` cycle. Mode 0 gives `ea_out` = `areg_val` with no write-back.
- R3: Postincrement gives `ea_out` = `areg_val` and `wb_val` = `areg_val` + step. The step is 1, 2 or 4 for size code 0 (byte), 1 (word) or 2 (long). Size code 3 acts as long. Addition wraps modulo 2^32.
- R4: Predecrement gives `ea_out` = `wb_val` = `areg_val` − step.
- R5: When `areg_num` is 7 (the stack pointer) and the size is byte, the step in modes 1 and 2 is 2.
- R6: Mode 3 uses one word. `ea_out` = `areg_val` + sign-extended word.
- R7: Mode 4 uses one word. `ea_out` = `areg_val` + sign-extended bits [7:0] of the word + `idx_val`.
- R8: Mode 5 uses one word, and `ea_out` = the sign-extended word. Mode 6 uses two words, and `ea_out` = {first, second}.
- R9: Modes 7 and 8 work like modes 3 and 4, but the base is `pc_val` (the address of the extension word) in place of `areg_val`.
- R10: Mode 9 uses one word for byte or word size. For byte size, `imm_out` = zero-extended bits [7:0]. For word size, `imm_out` = the zero-extended word. For long size it uses two words, with `imm_out` = {first, second}. `ea_out` reads 0.
- R11: `ext_ready` is high only while a word is still owed. A word is taken only in a cycle where `ext_valid` and `ext_ready` are both high. The unit waits for as long as `ext_valid` stays low. When idle, or for a mode with no words, `ext_valid` and `ext_word` have no effect. `done` rises in the cycle after the last word is taken.
- R12: `done` lasts exactly one cycle. `wb_en` is high only in that cycle and only for modes 1 and 2. Whenever `done` is low, `ea_out`, `imm_out` and `wb_val` read 0, and `wb_val` also reads 0 whenever `wb_en` is low.
- R13: A `start` strobe while an operation is in progress is ignored. The result follows the operands captured at the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted when idle) |
| mode_in | input | 4 | Addressing-mode code |
| size_in | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| areg_num | input | 3 | Number of the selected address register |
| areg_val | input | 32 | Value of the selected address register |
| idx_val | input | 32 | Index register value |
| pc_val | input | 32 | Address of the first extension word |
| ext_valid | input | 1 | Extension word offered |
| ext_word | input | 16 | Extension word |
| ext_ready | output | 1 | Unit is waiting for an extension word |
| done | output | 1 | One-cycle strobe marking a valid result |
| ea_out | output | 32 | Effective address |
| imm_out | output | 32 | Immediate operand |
| wb_en | output | 1 | Address register write enable |
| wb_val | output | 32 | Address register write-back value |

## Verification
If the state register holds a wrong value, `ext_ready` and `done` show it at once. A skipped wait state makes `done` rise one cycle early, with a short word count and a wrong address. A stuck wait state leaves `ext_ready` high with no `done` at all. A wrongly latched context register shows up only at the `done` cycle, as a wrong `ea_out`, `imm_out` or `wb_val`. For this reason the test vectors change the live operand inputs between `start` and `done`. A stale step selection shows up in the same cycle, as a write-back value off by 1, 2 or 3.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
    localparam int EXT_W  = 16;
    localparam int ADDR_W = 2 * EXT_W;
    localparam int RNUM_W = 3;

    typedef enum logic [3:0] {
        AM_IND      = 4'd0,
        AM_POSTINC  = 4'd1,
        AM_PREDEC   = 4'd2,
        AM_DISP     = 4'd3,
        AM_INDEX    = 4'd4,
        AM_ABS_S    = 4'd5,
        AM_ABS_L    = 4'd6,
        AM_PC_DISP  = 4'd7,
        AM_PC_INDEX = 4'd8,
        AM_IMM      = 4'd9
    } am_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } sz_e;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_WAIT_FIRST  = 2'd1,
        ST_WAIT_SECOND = 2'd2,
        ST_DONE        = 2'd3
    } st_e;

    // Number of extension words owed by a mode/size pair.
    function automatic logic [1:0] words_owed(input logic [3:0] m, input logic [1:0] s);
        logic [1:0] n;
        case (m)
            AM_DISP, AM_INDEX, AM_ABS_S, AM_PC_DISP, AM_PC_INDEX: n = 2'd1;
            AM_ABS_L: n = 2'd2;
            AM_IMM:   n = (s == SZ_BYTE || s == SZ_WORD) ? 2'd1 : 2'd2;
            default:  n = 2'd0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/eagu_step.sv
module eagu_step
    import eagu_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int SP_ALIGN = 2
) (
    input  logic [1:0]    size,
    input  logic          is_sp,
    output logic [AW-1:0] step
);
    localparam int BYTE_STEP = 1;
    localparam int WORD_STEP = 2;
    localparam int LONG_STEP = 4;

    always_comb begin
        unique case (size)
            SZ_BYTE: step = is_sp ? AW'(SP_ALIGN) : AW'(BYTE_STEP);
            SZ_WORD: step = AW'(WORD_STEP);
            default: step = AW'(LONG_STEP);
        endcase
    end
endmodule

// File: rtl/eagu_calc.sv
module eagu_calc
    import eagu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int EW = EXT_W
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [AW-1:0] base_reg,
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] pc_base,
    input  logic [AW-1:0] step,
    input  logic [EW-1:0] w_hi,
    input  logic [EW-1:0] w_cur,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] imm,
    output logic [AW-1:0] wb,
    output logic          wb_flag
);
    localparam int SH = 8;
    logic [AW-1:0] sx_full, sx_short, zx_short, zx_full, joined;

    assign sx_full  = {{(AW-EW){w_cur[EW-1]}}, w_cur};
    assign sx_short = {{(AW-SH){w_cur[SH-1]}}, w_cur[SH-1:0]};
    assign zx_short = {{(AW-SH){1'b0}}, w_cur[SH-1:0]};
    assign zx_full  = {{(AW-EW){1'b0}}, w_cur};
    assign joined   = {w_hi, w_cur};

    always_comb begin
        ea      = '0;
        imm     = '0;
        wb      = '0;
        wb_flag = 1'b0;
        unique case (mode)
            AM_POSTINC: begin
                ea      = base_reg;
                wb      = base_reg + step;
                wb_flag = 1'b1;
            end
            AM_PREDEC: begin
                ea      = base_reg - step;
                wb      = base_reg - step;
                wb_flag = 1'b1;
            end
            AM_DISP:     ea = base_reg + sx_full;
            AM_INDEX:    ea = base_reg + sx_short + index;
            AM_ABS_S:    ea = sx_full;
            AM_ABS_L:    ea = joined;
            AM_PC_DISP:  ea = pc_base + sx_full;
            AM_PC_INDEX: ea = pc_base + sx_short + index;
            AM_IMM: begin
                unique case (size)
                    SZ_BYTE: imm = zx_short;
                    SZ_WORD: imm = zx_full;
                    default: imm = joined;
                endcase
            end
            default:     ea = base_reg;
        endcase
    end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import eagu_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int EW     = EXT_W,
    parameter int RW     = RNUM_W,
    parameter int SP_NUM = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode_in,
    input  logic [1:0]    size_in,
    input  logic [RW-1:0] areg_num,
    input  logic [AW-1:0] areg_val,
    input  logic [AW-1:0] idx_val,
    input  logic [AW-1:0] pc_val,
    input  logic          ext_valid,
    input  logic [EW-1:0] ext_word,
    output logic          ext_ready,
    output logic          done,
    output logic [AW-1:0] ea_out,
    output logic [AW-1:0] imm_out,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    st_e state_q, state_d;

    // operand context captured at an accepted start
    logic [3:0]    mode_q;
    logic [1:0]    size_q;
    logic          sp_q;
    logic [AW-1:0] areg_q, idx_q, pc_q;
    logic [1:0]    owed_q;
    logic [EW-1:0] hi_q;

    // registered result
    logic [AW-1:0] ea_q, imm_q, wbv_q;
    logic          wbf_q;

    logic          idle, take, accept, finish;
    logic [1:0]    owed_live;
    logic          sp_live;
    logic [3:0]    c_mode;
    logic [1:0]    c_size;
    logic          c_sp;
    logic [AW-1:0] c_areg, c_idx, c_pc, c_step;
    logic [AW-1:0] r_ea, r_imm, r_wb;
    logic          r_wbf;

    assign idle      = (state_q == ST_IDLE);
    assign accept    = idle && start;
    assign owed_live = words_owed(mode_in, size_in);
    assign sp_live   = (areg_num == RW'(SP_NUM));
    assign take      = ext_valid && ext_ready;

    // Calculation inputs: live operands in IDLE, captured ones afterwards.
    assign c_mode = idle ? mode_in  : mode_q;
    assign c_size = idle ? size_in  : size_q;
    assign c_sp   = idle ? sp_live  : sp_q;
    assign c_areg = idle ? areg_val : areg_q;
    assign c_idx  = idle ? idx_val  : idx_q;
    assign c_pc   = idle ? pc_val   : pc_q;

    eagu_step #(.AW(AW)) u_step (
        .size  (c_size),
        .is_sp (c_sp),
        .step  (c_step)
    );

    eagu_calc #(.AW(AW), .EW(EW)) u_calc (
        .mode     (c_mode),
        .size     (c_size),
        .base_reg (c_areg),
        .index    (c_idx),
        .pc_base  (c_pc),
        .step     (c_step),
        .w_hi     (hi_q),
        .w_cur    (ext_word),
        .ea       (r_ea),
        .imm      (r_imm),
        .wb       (r_wb),
        .wb_flag  (r_wbf)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (owed_live == 2'd0) begin
                        state_d = ST_DONE;          // start-no-ext
                        finish  = 1'b1;
                    end else begin
                        state_d = ST_WAIT_FIRST;    // start-ext
                    end
                end
            end
            ST_WAIT_FIRST: begin
                if (take) begin
                    if (owed_q == 2'd1) begin
                        state_d = ST_DONE;          // first-last
                        finish  = 1'b1;
                    end else begin
                        state_d = ST_WAIT_SECOND;   // first-more
                    end
                end
            end
            ST_WAIT_SECOND: begin
                if (take) begin
                    state_d = ST_DONE;              // second-last
                    finish  = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;             // retire
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Context and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0; size_q <= '0; sp_q <= 1'b0;
            areg_q <= '0; idx_q <= '0; pc_q <= '0;
            owed_q <= '0; hi_q <= '0;
            ea_q <= '0; imm_q <= '0; wbv_q <= '0; wbf_q <= 1'b0;
        end else begin
            if (accept) begin
                mode_q <= mode_in;  size_q <= size_in; sp_q <= sp_live;
                areg_q <= areg_val; idx_q  <= idx_val; pc_q <= pc_val;
                owed_q <= owed_live;
            end
            if (state_q == ST_WAIT_FIRST && take) hi_q <= ext_word;
            if (finish) begin
                ea_q  <= r_ea;
                imm_q <= r_imm;
                wbv_q <= r_wb;
                wbf_q <= r_wbf;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        ext_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_WAIT_FIRST, ST_WAIT_SECOND: ext_ready = 1'b1;
            ST_DONE:                       done      = 1'b1;
            default: ;
        endcase
        wb_en   = done && wbf_q;
        ea_out  = done  ? ea_q  : '0;
        imm_out = done  ? imm_q : '0;
        wb_val  = wb_en ? wbv_q : '0;
    end
endmodule

// File: rtl/eagu_checker.sv
module eagu_checker
    import eagu_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int RW     = RNUM_W,
    parameter int SP_NUM = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [3:0]    mode_in,
    input logic [1:0]    size_in,
    input logic [RW-1:0] areg_num,
    input logic          ext_ready,
    input logic          done,
    input logic [AW-1:0] ea_out,
    input logic [AW-1:0] imm_out,
    input logic          wb_en,
    input logic [AW-1:0] wb_val
);
    logic          quiet;
    logic [3:0]    cap_mode;
    logic [1:0]    cap_size;
    logic          cap_sp;
    logic [AW-1:0] chk_step;

    assign quiet = !ext_ready && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_mode <= '0; cap_size <= '0; cap_sp <= 1'b0;
        end else if (start && quiet) begin
            cap_mode <= mode_in;
            cap_size <= size_in;
            cap_sp   <= (areg_num == RW'(SP_NUM));
        end
    end

    always_comb begin
        if (cap_size == 2'd0)      chk_step = cap_sp ? AW'(2) : AW'(1);
        else if (cap_size == 2'd1) chk_step = AW'(2);
        else                       chk_step = AW'(4);
    end

    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r12_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);
    a_r12_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
        !done |-> (ea_out == '0 && imm_out == '0 && wb_val == '0 && !wb_en));
    a_r11_no_ready_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !ext_ready);
    a_r2_noext_latency: assert property (@(posedge clk) disable iff (rst)
        (start && quiet && words_owed(mode_in, size_in) == 2'd0) |=> done);
    a_r11_ready_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && quiet && words_owed(mode_in, size_in) != 2'd0) |=> (ext_ready && !done));
    a_r3_postinc_step: assert property (@(posedge clk) disable iff (rst)
        (done && cap_mode == 4'd1) |-> (wb_en && wb_val == ea_out + chk_step));
    a_r4_predec_writeback: assert property (@(posedge clk) disable iff (rst)
        (done && cap_mode == 4'd2) |-> (wb_en && wb_val == ea_out));
endmodule

bind ea_gen_unit eagu_checker #(.AW(AW), .RW(RW), .SP_NUM(SP_NUM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode_in   (mode_in),
    .size_in   (size_in),
    .areg_num  (areg_num),
    .ext_ready (ext_ready),
    .done      (done),
    .ea_out    (ea_out),
    .imm_out   (imm_out),
    .wb_en     (wb_en),
    .wb_val    (wb_val)
);

// File: tb/sim_ea_gen_unit.sv
`timescale 1ns/1ps
module sim_ea_gen_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode_in = '0;
    logic [1:0]  size_in = '0;
    logic [2:0]  areg_num = '0;
    logic [31:0] areg_val = '0, idx_val = '0, pc_val = '0;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        ext_ready, done, wb_en;
    logic [31:0] ea_out, imm_out, wb_val;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ea_gen_unit u0 (
        .clk(clk), .rst(rst), .start(start), .mode_in(mode_in), .size_in(size_in),
        .areg_num(areg_num), .areg_val(areg_val), .idx_val(idx_val), .pc_val(pc_val),
        .ext_valid(ext_valid), .ext_word(ext_word), .ext_ready(ext_ready), .done(done),
        .ea_out(ea_out), .imm_out(imm_out), .wb_en(wb_en), .wb_val(wb_val)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic [1:0]  size;
        logic [2:0]  rnum;
        logic [31:0] areg;
        logic [31:0] idx;
        logic [31:0] pc;
        logic [15:0] w0;
        logic [15:0] w1;
        logic [1:0]  nw;
        logic [31:0] ea;
        logic [31:0] imm;
        logic        wbe;
        logic [31:0] wb;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        // mode size rn areg idx pc w0 w1 nw ea imm wbe wb
        '{4'd0, 2'd2, 3'd2, 32'h0000_1000, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_1000, 32'h0, 1'b0, 32'h0},           // R2
        '{4'd1, 2'd0, 3'd3, 32'h0000_2001, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_2001, 32'h0, 1'b1, 32'h0000_2002},   // R3 byte
        '{4'd1, 2'd0, 3'd7, 32'h0000_3000, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_3000, 32'h0, 1'b1, 32'h0000_3002},   // R5 sp byte
        '{4'd1, 2'd2, 3'd1, 32'hFFFF_FFFE, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'hFFFF_FFFE, 32'h0, 1'b1, 32'h0000_0002},   // R3 long wrap
        '{4'd2, 2'd1, 3'd4, 32'h0000_4000, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_3FFE, 32'h0, 1'b1, 32'h0000_3FFE},   // R4 word
        '{4'd2, 2'd0, 3'd7, 32'h0000_5000, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_4FFE, 32'h0, 1'b1, 32'h0000_4FFE},   // R5 sp byte
        '{4'd2, 2'd0, 3'd0, 32'h0000_5000, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_4FFF, 32'h0, 1'b1, 32'h0000_4FFF},   // R4 byte
        '{4'd2, 2'd3, 3'd5, 32'h0000_0100, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_00FC, 32'h0, 1'b1, 32'h0000_00FC},   // R4 size 3
        '{4'd3, 2'd1, 3'd2, 32'h0000_1000, 32'h0, 32'h0, 16'hFFF0, 16'h0, 2'd1, 32'h0000_0FF0, 32'h0, 1'b0, 32'h0},       // R6 negative
        '{4'd3, 2'd2, 3'd2, 32'h0000_1000, 32'h0, 32'h0, 16'h7FFF, 16'h0, 2'd1, 32'h0000_8FFF, 32'h0, 1'b0, 32'h0},       // R6 positive
        '{4'd4, 2'd1, 3'd6, 32'h0000_2000, 32'h30, 32'h0, 16'hAB80, 16'h0, 2'd1, 32'h0000_1FB0, 32'h0, 1'b0, 32'h0},     // R7
        '{4'd5, 2'd2, 3'd0, 32'h0, 32'h0, 32'h0, 16'h8000, 16'h0, 2'd1, 32'hFFFF_8000, 32'h0, 1'b0, 32'h0},              // R8 short
        '{4'd6, 2'd0, 3'd0, 32'h0, 32'h0, 32'h0, 16'h00AB, 16'hCDEF, 2'd2, 32'h00AB_CDEF, 32'h0, 1'b0, 32'h0},           // R8 long
        '{4'd7, 2'd1, 3'd0, 32'h1234, 32'h0, 32'h0000_0400, 16'hFFFE, 16'h0, 2'd1, 32'h0000_03FE, 32'h0, 1'b0, 32'h0},   // R9 disp
        '{4'd8, 2'd2, 3'd0, 32'h1234, 32'hFFFF_FFFF, 32'h0000_0400, 16'h0010, 16'h0, 2'd1, 32'h0000_040F, 32'h0, 1'b0, 32'h0}, // R9 index
        '{4'd9, 2'd0, 3'd0, 32'h0, 32'h0, 32'h0, 16'h12F7, 16'h0, 2'd1, 32'h0, 32'h0000_00F7, 1'b0, 32'h0},              // R10 byte
        '{4'd9, 2'd1, 3'd0, 32'h0, 32'h0, 32'h0, 16'hBEEF, 16'h0, 2'd1, 32'h0, 32'h0000_BEEF, 1'b0, 32'h0},              // R10 word
        '{4'd9, 2'd2, 3'd0, 32'h0, 32'h0, 32'h0, 16'hDEAD, 16'hBEEF, 2'd2, 32'h0, 32'hDEAD_BEEF, 1'b0, 32'h0},           // R10 long
        '{4'd12, 2'd1, 3'd3, 32'h0000_7777, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0, 32'h0000_7777, 32'h0, 1'b0, 32'h0}         // R2 undefined code
    };

    function automatic string req_of(input logic [3:0] m, input logic [2:0] rn, input logic [1:0] s);
        if ((m == 4'd1 || m == 4'd2) && rn == 3'd7 && s == 2'd0) return "R5";
        case (m)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5, 4'd6: return "R8";
            4'd7, 4'd8: return "R9";
            4'd9: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int used;
        bit got;
        string rq;
        used = 0;
        got = 1'b0;
        rq = req_of(v.mode, v.rnum, v.size);
        @(negedge clk);
        mode_in = v.mode; size_in = v.size; areg_num = v.rnum;
        areg_val = v.areg; idx_val = v.idx; pc_val = v.pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // disturb live operands: the result must follow the captured ones
        if (v.nw != 2'd0) begin
            areg_val = 32'hA5A5_A5A5; idx_val = 32'h5A5A_5A5A; pc_val = 32'h0BAD_0000; mode_in = 4'd0;
        end
        for (int c = 0; c < 8 && !got; c++) begin
            if (done) begin
                got = 1'b1;
                chk(rq, "ea_out",  ea_out,  v.ea);
                chk(rq, "imm_out", imm_out, v.imm);
                chk(rq, "wb_en",   {31'b0, wb_en}, {31'b0, v.wbe});
                chk(rq, "wb_val",  wb_val,  v.wb);
                chk("R11", "words taken", used, {30'b0, v.nw});
            end else if (ext_ready) begin
                ext_valid = 1'b1;
                ext_word  = (used == 0) ? v.w0 : v.w1;
                used++;
                @(negedge clk);
                ext_valid = 1'b0;
                ext_word  = 16'h0;
            end else begin
                @(negedge clk);
            end
        end
        chk("R12", "done seen", {31'b0, got}, 32'd1);
        @(negedge clk);
        chk("R12", "done after pulse", {31'b0, done}, 32'd0);
        chk("R12", "ea_out after pulse", ea_out, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL R11 watchdog: actual %0d cycles expected under 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {31'b0, done}, 32'd0);
        chk("R1", "ext_ready in reset", {31'b0, ext_ready}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ea_out after reset", ea_out, 32'd0);
        chk("R1", "imm_out after reset", imm_out, 32'd0);
        chk("R1", "wb after reset", {wb_val[30:0], wb_en}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R11: handshake while idle has no effect
        @(negedge clk);
        ext_valid = 1'b1; ext_word = 16'h5555;
        repeat (3) @(negedge clk);
        chk("R11", "idle valid ready", {31'b0, ext_ready}, 32'd0);
        chk("R11", "idle valid done", {31'b0, done}, 32'd0);
        // R11: valid held during a no-extension mode
        mode_in = 4'd0; size_in = 2'd1; areg_num = 3'd1; areg_val = 32'h0000_0010; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "noext done next cycle", {31'b0, done}, 32'd1);
        chk("R11", "noext ea with valid held", ea_out, 32'h0000_0010);
        ext_valid = 1'b0; ext_word = 16'h0;
        @(negedge clk);

        // R11: stall, then R13: start while busy is ignored
        mode_in = 4'd3; size_in = 2'd1; areg_num = 3'd2; areg_val = 32'h0000_1000; start = 1'b1;
        @(negedge clk);
        mode_in = 4'd0; areg_val = 32'h0000_9999;   // start still high while waiting
        repeat (4) @(negedge clk);
        start = 1'b0;
        chk("R11", "stall ready", {31'b0, ext_ready}, 32'd1);
        chk("R13", "stall no done", {31'b0, done}, 32'd0);
        ext_valid = 1'b1; ext_word = 16'h0004;
        @(negedge clk);
        ext_valid = 1'b0;
        chk("R13", "busy start ignored done", {31'b0, done}, 32'd1);
        chk("R13", "busy start ignored ea", ea_out, 32'h0000_1004);
        @(negedge clk);

        // R1: reset in the middle of an operation
        mode_in = 4'd6; size_in = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ext_valid = 1'b1; ext_word = 16'h1111;
        @(negedge clk);
        ext_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "mid reset ready", {31'b0, ext_ready}, 32'd0);
        chk("R1", "mid reset done", {31'b0, done}, 32'd0);
        @(negedge clk);
        run_vec(VEC[12]);   // R8 long after reset

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule